// File: doc/BRIEF.md
# Half-Step Prescaled Baud Generator

This block produces the timing pulses for an asynchronous serial port. It has two counter stages in series. The first stage is a prescaler. It divides the half-rate system clock by a factor from 1 to 16 in steps of one half. The second stage is a divisor. It divides the prescaled strobe by 1 to 2048 to form the 16x oversampling tick. A third, small counter divides the 16x tick by sixteen to give one pulse per serial bit. The resulting bit rate is f_clk / (32 · N · P).

Software or a neighbouring block loads a single 16-bit configuration word. A prescale code of zero selects the legacy clock path. In that case the generator stays silent and raises a flag that tells the surrounding logic to use the legacy path. Loading a new word restarts every stage, so the first pulse of the new rate comes one full new period after the load.

Top module: `baud_prescale_gen`

## Requirements
- R1: The configuration word holds the prescale code k in bits 15:11 and the divisor field d in bits 10:0. It is captured on a clock edge where `cfg_load` is high.
- R2: For k from 1 to 31, the prescaler factor is (k+1)/2 half-rate cycles, which equals k+1 system clocks. With d = 0, `tick16_o` repeats every k+1 clocks.
- R3: The divisor equals d+1, so `tick16_o` repeats every (k+1)·(d+1) clocks. The case d = 2047 gives a divisor of 2048.
- R4: `bit_tick_o` pulses on every sixteenth pulse of `tick16_o` and never at any other time. Its period is therefore 16·(k+1)·(d+1) clocks.
- R5: When k = 0, `compat_o` is high and both tick outputs stay low, whatever the value of d.
- R6: A load restarts all stages. Number the cycle right after the loading edge as 0. Then the first `tick16_o` falls in cycle (k+1)(d+1)−1, and the first `bit_tick_o` falls in cycle 16(k+1)(d+1)−1.
- R7: After reset the configuration word is zero. Therefore `compat_o` is high and both ticks are low.
- R8: Each tick is high for exactly one clock cycle. The two ticks are never high in two consecutive cycles.
- R9: Word 0x0800 gives the fastest rate: `tick16_o` every 2 clocks and `bit_tick_o` every 32 clocks, which is 625 kbaud from 20 MHz. Word 0xC804 gives a bit period of 2080 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture `cfg_word` and restart all stages |
| cfg_word | input | 16 | Prescale code (15:11) and divisor field (10:0) |
| tick16_o | output | 1 | 16x oversampling strobe |
| bit_tick_o | output | 1 | One strobe per serial bit |
| compat_o | output | 1 | High while the prescale code is zero |

## Verification
The bench builds the block with its default parameters: a 5-bit prescale code, an 11-bit divisor field and an oversampling ratio of 16. Because the prescale code is only five bits wide, random words cover every one of the 32 codes, both whole and half-step factors. Random words with small divisor fields let many full bit periods complete inside the run. Directed words cover the divisor of 2048, the code of 31, the fastest rate, the legacy bypass with a non-zero divisor field, and reloads that arrive in the middle of a period.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
    localparam int PRE_W_DEF   = 5;
    localparam int DIV_W_DEF   = 11;
    localparam int OS_LOG2_DEF = 4;

    function automatic int cfg_width(input int pre_w, input int div_w);
        return pre_w + div_w;
    endfunction
endpackage

// File: rtl/bpg_prescaler.sv
module bpg_prescaler #(
    parameter int PRE_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [PRE_W-1:0] code,
    output logic             strobe_o
);
    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic       run;
    logic       wrap;

    assign run  = (code != '0);
    assign wrap = (st_q.cnt == code);

    always_comb begin
        st_d = st_q;
        if (restart || !run) begin
            st_d.cnt = '0;
        end else if (wrap) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe_o = run && wrap;

    // R2: the prescale count never passes the loaded code
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= code);

    // R5: a zero code holds the prescaler idle
    a_r5_idle_when_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (code == '0) |-> !strobe_o);
endmodule

// File: rtl/bpg_divider.sv
module bpg_divider #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             step,
    input  logic [DIV_W-1:0] field,
    output logic             tick_o
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
    } div_state_t;

    div_state_t st_d, st_q;
    logic       at_end;

    assign at_end = (st_q.cnt == field);

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = at_end ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = step && at_end;

    // R3: the divisor count stays inside the programmed range
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= field);
endmodule

// File: rtl/bpg_oversample.sv
module bpg_oversample #(
    parameter int OS_LOG2 = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic tick_o
);
    typedef struct packed {
        logic [OS_LOG2-1:0] cnt;
    } os_state_t;

    os_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d.cnt = '0;
        end else if (step) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = step && (st_q.cnt == '1);

    // R4: a bit strobe is never followed directly by another
    a_r4_bit_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/baud_prescale_gen.sv
module baud_prescale_gen
    import bpg_pkg::*;
#(
    parameter int PRE_W   = PRE_W_DEF,
    parameter int DIV_W   = DIV_W_DEF,
    parameter int OS_LOG2 = OS_LOG2_DEF,
    localparam int CFG_W  = cfg_width(PRE_W, DIV_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             tick16_o,
    output logic             bit_tick_o,
    output logic             compat_o
);
    typedef struct packed {
        logic [PRE_W-1:0] pre_code;
        logic [DIV_W-1:0] div_field;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       pre_strobe;

    always_comb begin
        st_d = st_q;
        if (cfg_load) begin
            st_d.pre_code  = cfg_word[CFG_W-1:DIV_W];
            st_d.div_field = cfg_word[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign compat_o = (st_q.pre_code == '0);

    bpg_prescaler #(.PRE_W(PRE_W)) i_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (cfg_load),
        .code     (st_q.pre_code),
        .strobe_o (pre_strobe)
    );

    bpg_divider #(.DIV_W(DIV_W)) i_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_load),
        .step    (pre_strobe),
        .field   (st_q.div_field),
        .tick_o  (tick16_o)
    );

    bpg_oversample #(.OS_LOG2(OS_LOG2)) i_os (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (cfg_load),
        .step    (tick16_o),
        .tick_o  (bit_tick_o)
    );

    // R5: the legacy bypass keeps both outputs quiet
    a_r5_compat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        compat_o |-> (!tick16_o && !bit_tick_o));

    // R4: a bit strobe only ever falls on a 16x strobe
    a_r4_bit_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick_o |-> tick16_o);

    // R8: the 16x strobe is a single-cycle pulse
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tick16_o |=> !tick16_o);

    // R6: a load restarts the period, so the next cycle carries no tick
    a_r6_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_load |=> !tick16_o);
endmodule

// File: tb/test_baud_prescale_gen.sv
`timescale 1ns/1ps
module test_baud_prescale_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_load = 1'b0;
    logic [15:0] cfg_word = '0;
    logic        tick16_o, bit_tick_o, compat_o;

    int   n_checks = 0;
    int   n_fail   = 0;
    int   cycles   = 0;
    bit   done     = 1'b0;

    // reference model state
    logic [15:0] m_cfg = '0;
    longint      m_cnt = 0;

    always #2.5 clk = ~clk;

    baud_prescale_gen i_baud_prescale_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_word   (cfg_word),
        .tick16_o   (tick16_o),
        .bit_tick_o (bit_tick_o),
        .compat_o   (compat_o)
    );

    function automatic longint period_of(input logic [15:0] w);
        return longint'(w[15:11] + 1) * longint'(w[10:0] + 1);
    endfunction

    function automatic logic exp_tick(input logic [15:0] w, input longint c, input int mult);
        if (w[15:11] == 5'd0) return 1'b0;
        return ((c + 1) % (period_of(w) * mult)) == 0;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b (word %h, cycle %0d)",
                     req, what, act, exp, m_cfg, m_cnt);
        end
    endtask

    task automatic compare(input string tag);
        chk(tag, tick16_o, exp_tick(m_cfg, m_cnt, 1), "tick16");
        chk("R4", bit_tick_o, exp_tick(m_cfg, m_cnt, 16), "bit_tick");
        chk("R5", compat_o, (m_cfg[15:11] == 5'd0), "compat");
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        if (cfg_load) begin
            m_cfg = cfg_word;
            m_cnt = 0;
        end else begin
            m_cnt++;
        end
        @(negedge clk);
        cfg_load = 1'b0;
        compare(tag);
    endtask

    task automatic run_cfg(input logic [15:0] w, input int n, input string tag);
        cfg_load = 1'b1;
        cfg_word = w;
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        int unsigned seed;
        logic [15:0] w;
        seed = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7: reset state
        chk("R7", compat_o, 1'b1, "compat after reset");
        chk("R7", tick16_o, 1'b0, "tick16 after reset");
        chk("R7", bit_tick_o, 1'b0, "bit_tick after reset");
        for (int i = 0; i < 8; i++) step("R7");

        run_cfg(16'h0800, 100, "R9");   // fastest rate
        run_cfg(16'hC804, 2200, "R9");  // P=13, N=5
        run_cfg(16'h0800 | 16'd0, 40, "R1");
        run_cfg({5'd31, 11'd0}, 600, "R2");     // code 31, factor 16
        run_cfg({5'd2, 11'd2}, 300, "R2");      // half step 1.5
        run_cfg({5'd0, 11'd5}, 80, "R5");       // bypass, divisor ignored
        run_cfg({5'd1, 11'd2047}, 8300, "R3");  // divisor 2048
        run_cfg({5'd3, 11'd1}, 37, "R6");       // reload mid period
        run_cfg({5'd6, 11'd3}, 500, "R6");
        run_cfg({5'd4, 11'd0}, 3, "R6");
        run_cfg({5'd4, 11'd0}, 200, "R6");

        for (int r = 0; r < 60; r++) begin
            w[15:11] = ($urandom_range(0, 9) == 0) ? 5'd0 : 5'($urandom_range(1, 31));
            w[10:0]  = 11'($urandom_range(0, 12));
            run_cfg(w, $urandom_range(20, 1500), (r % 2 == 0) ? "R3" : "R8");
        end
        finish_run();
    end
endmodule